// File: doc/BRIEF.md
# Address-Latching Bytewide Memory Slave

This block is a clock-driven model of an 8192 x 8 parallel memory with an asynchronous-style, active-low control interface. The chip enable, write enable and output enable pins, together with the 13-bit address and the write data, pass through a two-flop synchroniser. Every decision is then taken on the synchronised copies.

A memory cycle opens when the synchronised chip enable is seen low. The address present at that moment is latched and held for the whole cycle. The cycle then runs for a fixed access interval of `ACC_CYC` clocks and finishes with a precharge interval of `PRE_CYC` clocks. A cycle cannot be aborted. If a new chip-enable fall arrives during precharge, it waits and starts only once precharge is over.

If write enable is already low when the cycle opens, the cycle is a write and the bus is never driven. If write enable falls later, the cycle begins as a read and turns into a write at that point. A write commits on the first rise of either write enable or chip enable. The data bus is split into `din`, `dout` and a drive-enable output `dout_en`.

Top module: `bwmem_top`

## Requirements
- R1: After reset `dout_en` is 0 and no cycle is in progress.
- R2: The address is latched when a cycle opens. Changing `addr` afterwards does not alter which location the cycle reads or writes.
- R3: All 8192 locations, selected by the 13-bit address, are independent. Neighbours across a 1K boundary (for example 0x03FF and 0x0400) keep separate values.
- R4: A cycle runs its full access interval even if chip enable rises early. It then enters precharge and does not drive the bus.
- R5: If `we_n` is low when the cycle opens, the cycle is a write. `dout_en` stays 0 throughout, even with `oe_n` low.
- R6: `dout_en` is 1 only while the synchronised `oe_n` is low. With `oe_n` high a read cycle leaves the bus undriven, and lowering `oe_n` later starts the drive.
- R7: On a read, drive is withheld until the access time has passed. With `oe_n` already low, `dout_en` first rises at the (ACC_CYC+3)-th rising clock edge after `ce_n` falls: two synchroniser edges, one start edge and ACC_CYC access edges. `dout` then holds the stored byte.
- R8: If `we_n` falls during a read cycle, the cycle becomes a write. `dout_en` drops at the third rising edge after the fall and stays 0.
- R9: A write stores the `din` value present at the first rise of `we_n` or `ce_n`. Changes to `din` after that rise are not stored.
- R10: A precharge of PRE_CYC clocks follows every cycle. A `ce_n` fall that arrives during precharge starts its cycle only after precharge ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | 13 | Byte address |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data toward the bus |
| dout_en | output | 1 | High when the block drives the bus |

## Verification
The hardest overlaps are a write conversion that happens while read data is already on the bus, and a new chip-enable fall that lands while the previous cycle is still running or precharging. The first is provoked by dropping `we_n` in the middle of a driven read. The bench judges it by the exact edge at which `dout_en` falls and by the value read back later. The second is provoked by releasing `ce_n` early and lowering it again within a clock. It is judged by showing that no drive appears where an unheld start would have produced one, and that the delayed cycle later returns the byte at the second address.

// File: rtl/bwmem_pkg.sv
package bwmem_pkg;
    localparam int ADDR_W = 13;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RUN,
        PH_HOLD,
        PH_PRE
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } ctl_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic int cnt_width(int a, int b);
        return $clog2(((a > b) ? a : b) + 1);
    endfunction
endpackage

// File: rtl/bwmem_sync.sv
module bwmem_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= RST_VAL;
                else     stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bwmem_array.sv
module bwmem_array
    import bwmem_pkg::*;
(
    input  logic              clk,
    input  wr_req_t           wr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr.en) mem[wr.addr] <= wr.data;
        rd_q <= mem[rd_addr];
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/bwmem_seq.sv
module bwmem_seq
    import bwmem_pkg::*;
#(
    parameter int ACC_CYC = 6,
    parameter int PRE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl_s,
    input  bus_t              bus_s,
    output wr_req_t           wr_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              drive_o
);
    localparam int CW = cnt_width(ACC_CYC, PRE_CYC);
    localparam logic [CW-1:0] ACC_LAST = CW'(ACC_CYC - 1);
    localparam logic [CW-1:0] PRE_LAST = CW'(PRE_CYC - 1);

    phase_e            state_q;
    logic [CW-1:0]     cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic              is_wr_q, wr_open_q, armed_q, early_q, ce_d_q, we_d_q;

    logic ce_rise, we_rise, we_fall, start, active, wr_close, wr_opn;

    assign ce_rise  = !ce_d_q && ctl_s.ce_n;
    assign we_rise  = !we_d_q && ctl_s.we_n;
    assign we_fall  = we_d_q && !ctl_s.we_n;
    assign start    = (state_q == PH_IDLE) && !ctl_s.ce_n && armed_q;
    assign active   = (state_q == PH_RUN) || (state_q == PH_HOLD);
    assign wr_close = wr_open_q && (ce_rise || we_rise);
    assign wr_opn   = we_fall && !ctl_s.ce_n && !wr_open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= PH_IDLE;
            cnt_q     <= '0;
            addr_q    <= '0;
            is_wr_q   <= 1'b0;
            wr_open_q <= 1'b0;
            armed_q   <= 1'b0;
            early_q   <= 1'b0;
            ce_d_q    <= 1'b1;
            we_d_q    <= 1'b1;
        end else begin
            ce_d_q <= ctl_s.ce_n;
            we_d_q <= ctl_s.we_n;
            if (ctl_s.ce_n) armed_q <= 1'b1;
            case (state_q)
                PH_IDLE: if (start) begin
                    state_q   <= PH_RUN;
                    cnt_q     <= '0;
                    addr_q    <= bus_s.addr;
                    is_wr_q   <= !ctl_s.we_n;
                    wr_open_q <= !ctl_s.we_n;
                    armed_q   <= 1'b0;
                    early_q   <= 1'b0;
                end
                PH_RUN: begin
                    cnt_q <= cnt_q + CW'(1);
                    if (ce_rise) early_q <= 1'b1;
                    if (cnt_q == ACC_LAST) begin
                        cnt_q   <= '0;
                        state_q <= (ctl_s.ce_n || early_q || ce_rise) ? PH_PRE : PH_HOLD;
                    end
                end
                PH_HOLD: if (ctl_s.ce_n) begin
                    state_q <= PH_PRE;
                    cnt_q   <= '0;
                end
                default: begin
                    cnt_q <= cnt_q + CW'(1);
                    if (cnt_q == PRE_LAST) begin
                        cnt_q   <= '0;
                        state_q <= PH_IDLE;
                    end
                end
            endcase
            if (active) begin
                if (wr_close) wr_open_q <= 1'b0;
                else if (wr_opn) begin
                    wr_open_q <= 1'b1;
                    is_wr_q   <= 1'b1;
                end
            end
        end
    end

    assign wr_o.en   = active && wr_close;
    assign wr_o.addr = addr_q;
    assign wr_o.data = bus_s.data;
    assign addr_o    = addr_q;
    assign drive_o   = (state_q == PH_HOLD) && !is_wr_q && !ctl_s.oe_n && !ctl_s.ce_n;

    a_r4_run_completes: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_RUN && cnt_q != ACC_LAST) |=> (state_q == PH_RUN));

    a_r10_precharge_full: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_PRE && cnt_q != PRE_LAST) |=> (state_q == PH_PRE));

    a_r2_addr_held: assert property (@(posedge clk) disable iff (rst)
        (state_q != PH_IDLE && $past(state_q) != PH_IDLE) |-> $stable(addr_q));

    a_r8_convert_stops_drive: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_HOLD && we_fall && !ctl_s.ce_n) |=> !drive_o);
endmodule

// File: rtl/bwmem_top.sv
module bwmem_top
    import bwmem_pkg::*;
#(
    parameter int ACC_CYC     = 6,
    parameter int PRE_CYC     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    localparam int CTL_W = $bits(ctl_t);
    localparam int BUS_W = $bits(bus_t);

    ctl_t              ctl_raw, ctl_s;
    bus_t              bus_raw, bus_s;
    wr_req_t           wr;
    logic [ADDR_W-1:0] rd_addr;

    assign ctl_raw = '{ce_n: ce_n, we_n: we_n, oe_n: oe_n};
    assign bus_raw = '{addr: addr, data: din};

    bwmem_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTL_W{1'b1}})) u_ctl_sync (
        .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s)
    );

    bwmem_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL({BUS_W{1'b0}})) u_bus_sync (
        .clk(clk), .rst(rst), .d(bus_raw), .q(bus_s)
    );

    bwmem_seq #(.ACC_CYC(ACC_CYC), .PRE_CYC(PRE_CYC)) u_seq (
        .clk(clk), .rst(rst), .ctl_s(ctl_s), .bus_s(bus_s),
        .wr_o(wr), .addr_o(rd_addr), .drive_o(dout_en)
    );

    bwmem_array u_array (
        .clk(clk), .wr(wr), .rd_addr(rd_addr), .rd_data(dout)
    );

    a_r6_oe_gates_drive: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> !ctl_s.oe_n);

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !dout_en);
endmodule

// File: tb/bwmem_top_tb_top.sv
module bwmem_top_tb_top;
    localparam int ACC = 6;
    localparam int PRE = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [12:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bwmem_top #(.ACC_CYC(ACC), .PRE_CYC(PRE), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    // bit 21: 1 = write-enable-controlled write; [20:8] address; [7:0] data
    localparam logic [21:0] VEC [8] = '{
        {1'b0, 13'h0000, 8'hA5}, {1'b1, 13'h03FF, 8'h3C},
        {1'b0, 13'h0400, 8'hC3}, {1'b1, 13'h1FFF, 8'h5A},
        {1'b0, 13'h1000, 8'h0F}, {1'b1, 13'h0FFF, 8'hF0},
        {1'b0, 13'h0001, 8'h81}, {1'b1, 13'h1C00, 8'h7E}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic negs(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        negs(PRE + ACC + 8);
    endtask

    task automatic wr_ce(input logic [12:0] a, input logic [7:0] d);
        addr = a; din = d; we_n = 1'b0;
        negs(1); ce_n = 1'b0;
        negs(ACC + 5); ce_n = 1'b1;
        negs(1); we_n = 1'b1;
        settle();
    endtask

    task automatic wr_we(input logic [12:0] a, input logic [7:0] d);
        addr = a; oe_n = 1'b1; ce_n = 1'b0;
        negs(3); we_n = 1'b0; din = d;
        negs(ACC + 5); we_n = 1'b1;
        negs(3); ce_n = 1'b1;
        settle();
    endtask

    task automatic rd(input logic [12:0] a, output logic [7:0] d, output logic en);
        addr = a; oe_n = 1'b0; ce_n = 1'b0;
        negs(ACC + 6);
        d = dout; en = dout_en;
        settle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       en;
        bit         seen;

        negs(4);
        rst = 1'b0;
        negs(1);
        chk(dout_en == 1'b0, "R1 reset drive", dout_en, 0);
        settle();

        // R3: table of writes in both styles, then read back all
        foreach (VEC[i]) begin
            if (VEC[i][21]) wr_we(VEC[i][20:8], VEC[i][7:0]);
            else            wr_ce(VEC[i][20:8], VEC[i][7:0]);
        end
        foreach (VEC[i]) begin
            rd(VEC[i][20:8], d, en);
            chk(en && d == VEC[i][7:0], "R3 table readback", {en, d}, {1'b1, VEC[i][7:0]});
        end

        // R7: exact edge of first drive, oe low before access ends
        addr = 13'h03FF; oe_n = 1'b0; ce_n = 1'b0;
        repeat (ACC + 2) @(posedge clk);
        @(negedge clk);
        chk(dout_en == 1'b0, "R7 withheld before access", dout_en, 0);
        @(posedge clk); @(negedge clk);
        chk(dout_en == 1'b1, "R7 drive at access end", dout_en, 1);
        chk(dout == 8'h3C, "R7 data", dout, 8'h3C);
        settle();

        // R2: address changed after capture
        addr = 13'h0400; oe_n = 1'b0; ce_n = 1'b0;
        negs(3); addr = 13'h0000;
        negs(ACC + 4);
        chk(dout_en && dout == 8'hC3, "R2 latched address", dout, 8'hC3);
        settle();

        // R6: oe high leaves bus undriven, lowering it starts drive
        addr = 13'h1C00; oe_n = 1'b1; ce_n = 1'b0;
        negs(ACC + 6);
        chk(dout_en == 1'b0, "R6 oe high no drive", dout_en, 0);
        oe_n = 1'b0; negs(4);
        chk(dout_en && dout == 8'h7E, "R6 oe low drives", dout, 8'h7E);
        settle();

        // R5: write enable low at cycle open, oe low throughout
        addr = 13'h0002; din = 8'h6B; we_n = 1'b0; oe_n = 1'b0;
        negs(1); ce_n = 1'b0;
        seen = 0;
        for (int k = 0; k < ACC + 6; k++) begin
            @(negedge clk);
            if (dout_en) seen = 1;
        end
        chk(!seen, "R5 no drive in write", seen, 0);
        ce_n = 1'b1; negs(1); we_n = 1'b1;
        settle();
        rd(13'h0002, d, en);
        chk(en && d == 8'h6B, "R5 write stored", d, 8'h6B);

        // R8: read converted to write by a late we fall
        addr = 13'h0001; oe_n = 1'b0; ce_n = 1'b0;
        negs(ACC + 6);
        chk(dout_en == 1'b1, "R8 read drives first", dout_en, 1);
        we_n = 1'b0; din = 8'h99;
        repeat (2) @(posedge clk); @(negedge clk);
        chk(dout_en == 1'b1, "R8 drive before sync", dout_en, 1);
        @(posedge clk); @(negedge clk);
        chk(dout_en == 1'b0, "R8 drive dropped", dout_en, 0);
        negs(3); we_n = 1'b1; negs(3);
        settle();
        rd(13'h0001, d, en);
        chk(en && d == 8'h99, "R8 converted write stored", d, 8'h99);

        // R9: chip enable rises first, later din change ignored
        addr = 13'h0400; din = 8'h11; we_n = 1'b0;
        negs(1); ce_n = 1'b0;
        negs(ACC + 5); ce_n = 1'b1;
        negs(1); din = 8'h22;
        negs(1); we_n = 1'b1;
        settle();
        rd(13'h0400, d, en);
        chk(en && d == 8'h11, "R9 data at first rise", d, 8'h11);

        // R4 / R10: early ce release, re-fall held off by precharge
        addr = 13'h1FFF; oe_n = 1'b0; ce_n = 1'b0;
        negs(2); ce_n = 1'b1;
        negs(1); ce_n = 1'b0; addr = 13'h1000;
        repeat (9) @(posedge clk); @(negedge clk);
        chk(dout_en == 1'b0, "R10 start held off", dout_en, 0);
        repeat (8) @(posedge clk); @(negedge clk);
        chk(dout_en == 1'b1, "R4 cycle completed then restart", dout_en, 1);
        chk(dout == 8'h0F, "R10 held cycle data", dout, 8'h0F);
        settle();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule